// File: doc/BRIEF.md
# SD Card Command Path Sequencer

This block puts one host command onto the single-bit command line of an SD or MMC card and, when asked, collects the card's reply. Software writes a 32-bit command argument together with a command word whose top bit is a start flag. Once idle, the sequencer takes the command. It can first send a run of initialization clocks. It then shifts out a 48-bit frame: start bit, direction bit, 6-bit index, argument, CRC7 and end bit. It then releases the line and waits for a short (48-bit) or long (136-bit) response.

While a response arrives the block stores the 6 bits that follow the direction bit as the response index and collects the payload. At the end it checks the framing bits, the CRC and the echoed index. One done pulse marks the end of every command, whether it succeeded or failed. The error flags stay readable until the next command is taken. A command word that asks for a clock update only finishes at once and never drives the line. Each clock cycle of `clk` is one card clock. The bidirectional line is split into an input, an output and an output enable.

The sequencer's current step is visible on a 4-bit state field with a fixed encoding.

Top module: `sdc_cmd_seq`

## Requirements
- R1: After reset the state field is 0 (idle), `cmd_oe` and `cmd_done` are low, no start is pending and every error flag is low.
- R2: A write with `cmd_word` bit 31 set raises `cmd_pending`. The sequencer takes the command on the next clock and `cmd_pending` clears. A write made while a start is pending, or while the state is not idle, is ignored.
- R3: A command drives exactly these 48 bits MSB first, with `cmd_oe` high only for them: 0, 1, the index from `cmd_word[5:0]`, the 32-bit argument, a CRC7 and a 1. The CRC7 uses x^7+x^3+1, starts from zero and covers the first 40 bits.
- R4: With `cmd_word` bit 15 set, 80 clocks of logic 1 are driven (with `cmd_oe` high) before the frame.
- R5: With `cmd_word` bit 21 set, the command never raises `cmd_oe` and pulses `cmd_done` in the clock after it is taken, with all error flags low.
- R6: The state field uses the fixed encoding 0 idle, 1 init clocks, 2 send start, 3 send direction, 4 send index and argument, 5 send CRC, 6 send end, 7 await start, 8 interrupt reply (never entered), 9 receive direction, 10 receive index, 11 receive payload, 12 receive CRC, 13 receive end, 14 wait before next command, 15 turnaround.
- R7: With `cmd_word` bit 6 set, the line is released for 2 clocks after the end bit. A start bit (0) is then accepted within `resp_timeout` clocks (0 means 256). If none arrives, `err_timeout` and `cmd_done` rise exactly 2+`resp_timeout` clocks after the release.
- R8: For a short response (`cmd_word` bit 7 clear), `resp_index` takes the received 6-bit index and `resp_data` holds the 32 payload bits in [31:0] with zeros above. `err_index` is set when the received index differs from the sent one.
- R9: For a long response (`cmd_word` bit 7 set), `resp_data` holds the 128 bits that follow the 6-bit field: 120 payload bits, then the CRC7, then the end bit. The CRC is computed over the 120 payload bits only.
- R10: A CRC mismatch sets `err_crc` only when `cmd_word` bit 8 is set. A received direction bit of 1 sets `err_start`, and a received end bit of 0 sets `err_end`.
- R11: Every command produces exactly one single-cycle `cmd_done` pulse. Error flags are cleared when a command is taken and hold their value after done.
- R12: After done the state is 14 for 8 clocks, with the line released, and then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one card clock per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Write strobe for command word and argument |
| cmd_word | input | 32 | Command word (index, flags, start bit 31) |
| cmd_arg | input | 32 | Command argument |
| resp_timeout | input | 8 | Response start-bit window in clocks, 0 = 256 |
| cmd_in | input | 1 | Sampled command line |
| cmd_out | output | 1 | Value driven onto the command line |
| cmd_oe | output | 1 | Command line output enable |
| seq_state | output | 4 | Current sequencer step, fixed encoding |
| cmd_pending | output | 1 | Start flag still waiting to be taken |
| cmd_done | output | 1 | One-cycle end-of-command pulse |
| resp_index | output | 6 | Index field of the last response |
| resp_data | output | 128 | Captured response payload |
| err_timeout | output | 1 | No response start bit in the window |
| err_crc | output | 1 | Response CRC mismatch |
| err_start | output | 1 | Response direction bit was 1 |
| err_end | output | 1 | Response end bit was 0 |
| err_index | output | 1 | Short response index differs from the sent index |

## Verification
The bench builds the block with its default parameters: 80 init clocks, a 2-clock turnaround, an 8-clock wait before the next command, 32-bit short and 120-bit long payloads. These values make the exact timeout latency (2 plus the window) measurable for both a small window and the 256-clock window coded as 0. A start bit can also be sent in the very last cycle of a window. A full init-plus-frame sequence (128 driven bits) and a long 136-bit response both fit in short runs.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_INIT     = 4'd1,
        ST_TX_START = 4'd2,
        ST_TX_DIR   = 4'd3,
        ST_TX_BODY  = 4'd4,
        ST_TX_CRC   = 4'd5,
        ST_TX_END   = 4'd6,
        ST_RX_START = 4'd7,
        ST_RX_IRQ   = 4'd8,
        ST_RX_DIR   = 4'd9,
        ST_RX_IDX   = 4'd10,
        ST_RX_BODY  = 4'd11,
        ST_RX_CRC   = 4'd12,
        ST_RX_END   = 4'd13,
        ST_NCC      = 4'd14,
        ST_TURN     = 4'd15
    } seq_state_e;

    // command word bit positions
    localparam int CW_W        = 32;
    localparam int CW_RESP_BIT = 6;
    localparam int CW_LONG_BIT = 7;
    localparam int CW_CRC_BIT  = 8;
    localparam int CW_INIT_BIT = 15;
    localparam int CW_UPD_BIT  = 21;
    localparam int CW_GO_BIT   = 31;

    localparam int CRC_W = 7;

    // one serial step of x^7 + x^3 + 1
    function automatic logic [CRC_W-1:0] crc7_next(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
    endfunction

endpackage

// File: rtl/sdc_crc7.sv
module sdc_crc7 (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       en,
    input  logic       din,
    output logic [6:0] crc
);
    logic [6:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr)     crc_d = '0;
        else if (en) crc_d = sdc_pkg::crc7_next(crc_q, din);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/sdc_resp_cap.sv
module sdc_resp_cap #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (clr)     q_d = '0;
        else if (en) q_d = {q_q[W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/sdc_cmd_seq.sv
module sdc_cmd_seq
    import sdc_pkg::*;
#(
    parameter int INIT_CLKS = 80,
    parameter int TURN_CLKS = 2,
    parameter int NCC_CLKS  = 8,
    parameter int IDX_W     = 6,
    parameter int ARG_W     = 32,
    parameter int TO_W      = 8,
    parameter int SHORT_PAY = 32,
    parameter int LONG_PAY  = 120,
    localparam int RESP_W   = LONG_PAY + CRC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CW_W-1:0]   cmd_word,
    input  logic [ARG_W-1:0]  cmd_arg,
    input  logic [TO_W-1:0]   resp_timeout,
    input  logic              cmd_in,
    output logic              cmd_out,
    output logic              cmd_oe,
    output logic [3:0]        seq_state,
    output logic              cmd_pending,
    output logic              cmd_done,
    output logic [IDX_W-1:0]  resp_index,
    output logic [RESP_W-1:0] resp_data,
    output logic              err_timeout,
    output logic              err_crc,
    output logic              err_start,
    output logic              err_end,
    output logic              err_index
);
    localparam int TXB_W = IDX_W + ARG_W;
    localparam int M1 = (INIT_CLKS > LONG_PAY) ? INIT_CLKS : LONG_PAY;
    localparam int M2 = (M1 > TXB_W) ? M1 : TXB_W;
    localparam int M3 = (M2 > NCC_CLKS) ? M2 : NCC_CLKS;
    localparam int M4 = (M3 > (1 << TO_W)) ? M3 : (1 << TO_W);
    localparam int CNT_W = $clog2(M4 + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic              go;
        logic [CW_W-1:0]   word;
        logic [ARG_W-1:0]  arg;
        logic [TXB_W-1:0]  tx_sh;
        logic [IDX_W-1:0]  rx_idx;
        logic [IDX_W-1:0]  resp_idx;
        logic [CRC_W-1:0]  rcrc;
        logic              done;
        logic              f_to;
        logic              f_crc;
        logic              f_sbit;
        logic              f_ebit;
        logic              f_idx;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             crc_clr, crc_en, crc_din;
    logic [CRC_W-1:0] crc_val;
    logic             cap_clr, cap_en;
    logic [TO_W-1:0]  to_last;
    logic             is_long;

    sdc_crc7 u_crc (
        .clk (clk), .rst_n (rst_n), .clr (crc_clr), .en (crc_en),
        .din (crc_din), .crc (crc_val)
    );

    sdc_resp_cap #(.W(RESP_W)) u_cap (
        .clk (clk), .rst_n (rst_n), .clr (cap_clr), .en (cap_en),
        .din (cmd_in), .q (resp_data)
    );

    assign to_last = resp_timeout - TO_W'(1);
    assign is_long = r_q.word[CW_LONG_BIT];

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        crc_clr = 1'b0;
        crc_en  = 1'b0;
        crc_din = 1'b0;
        cap_clr = 1'b0;
        cap_en  = 1'b0;
        cmd_oe  = 1'b0;
        cmd_out = 1'b1;
        case (r_q.state)
            ST_IDLE: begin
                if (cmd_wr && !r_q.go) begin
                    r_d.go   = cmd_word[CW_GO_BIT];
                    r_d.word = cmd_word;
                    r_d.arg  = cmd_arg;
                end else if (r_q.go) begin
                    r_d.go     = 1'b0;
                    r_d.f_to   = 1'b0;
                    r_d.f_crc  = 1'b0;
                    r_d.f_sbit = 1'b0;
                    r_d.f_ebit = 1'b0;
                    r_d.f_idx  = 1'b0;
                    if (r_q.word[CW_UPD_BIT]) begin
                        r_d.done = 1'b1;
                    end else begin
                        crc_clr   = 1'b1;
                        cap_clr   = 1'b1;
                        r_d.tx_sh = {r_q.word[IDX_W-1:0], r_q.arg};
                        if (r_q.word[CW_INIT_BIT]) begin
                            r_d.state = ST_INIT;
                            r_d.cnt   = CNT_W'(INIT_CLKS - 1);
                        end else begin
                            r_d.state = ST_TX_START;
                        end
                    end
                end
            end
            ST_INIT: begin
                cmd_oe = 1'b1;
                if (r_q.cnt == '0) r_d.state = ST_TX_START;
                else               r_d.cnt   = r_q.cnt - CNT_W'(1);
            end
            ST_TX_START: begin
                cmd_oe    = 1'b1;
                cmd_out   = 1'b0;
                crc_en    = 1'b1;
                crc_din   = 1'b0;
                r_d.state = ST_TX_DIR;
            end
            ST_TX_DIR: begin
                cmd_oe    = 1'b1;
                crc_en    = 1'b1;
                crc_din   = 1'b1;
                r_d.state = ST_TX_BODY;
                r_d.cnt   = CNT_W'(TXB_W - 1);
            end
            ST_TX_BODY: begin
                cmd_oe    = 1'b1;
                cmd_out   = r_q.tx_sh[TXB_W-1];
                crc_en    = 1'b1;
                crc_din   = r_q.tx_sh[TXB_W-1];
                r_d.tx_sh = {r_q.tx_sh[TXB_W-2:0], 1'b0};
                if (r_q.cnt == '0) begin
                    r_d.state = ST_TX_CRC;
                    r_d.cnt   = CNT_W'(CRC_W - 1);
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_TX_CRC: begin
                cmd_oe  = 1'b1;
                cmd_out = crc_val[r_q.cnt[2:0]];
                if (r_q.cnt == '0) r_d.state = ST_TX_END;
                else               r_d.cnt   = r_q.cnt - CNT_W'(1);
            end
            ST_TX_END: begin
                cmd_oe  = 1'b1;
                crc_clr = 1'b1;
                if (r_q.word[CW_RESP_BIT]) begin
                    r_d.state = ST_TURN;
                    r_d.cnt   = CNT_W'(TURN_CLKS - 1);
                end else begin
                    r_d.done  = 1'b1;
                    r_d.state = ST_NCC;
                    r_d.cnt   = CNT_W'(NCC_CLKS - 1);
                end
            end
            ST_TURN: begin
                if (r_q.cnt == '0) begin
                    r_d.state = ST_RX_START;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_RX_START: begin
                if (!cmd_in) begin
                    crc_en    = !is_long;
                    crc_din   = 1'b0;
                    r_d.state = ST_RX_DIR;
                end else if (r_q.cnt[TO_W-1:0] == to_last) begin
                    r_d.f_to  = 1'b1;
                    r_d.done  = 1'b1;
                    r_d.state = ST_NCC;
                    r_d.cnt   = CNT_W'(NCC_CLKS - 1);
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_RX_DIR: begin
                r_d.f_sbit = cmd_in;
                crc_en     = !is_long;
                crc_din    = cmd_in;
                r_d.state  = ST_RX_IDX;
                r_d.cnt    = CNT_W'(IDX_W - 1);
            end
            ST_RX_IDX: begin
                crc_en     = !is_long;
                crc_din    = cmd_in;
                r_d.rx_idx = {r_q.rx_idx[IDX_W-2:0], cmd_in};
                if (r_q.cnt == '0) begin
                    r_d.resp_idx = {r_q.rx_idx[IDX_W-2:0], cmd_in};
                    r_d.state    = ST_RX_BODY;
                    r_d.cnt      = is_long ? CNT_W'(LONG_PAY - 1) : CNT_W'(SHORT_PAY - 1);
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_RX_BODY: begin
                cap_en  = 1'b1;
                crc_en  = 1'b1;
                crc_din = cmd_in;
                if (r_q.cnt == '0) begin
                    r_d.state = ST_RX_CRC;
                    r_d.cnt   = CNT_W'(CRC_W - 1);
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_RX_CRC: begin
                cap_en   = is_long;
                r_d.rcrc = {r_q.rcrc[CRC_W-2:0], cmd_in};
                if (r_q.cnt == '0) r_d.state = ST_RX_END;
                else               r_d.cnt   = r_q.cnt - CNT_W'(1);
            end
            ST_RX_END: begin
                cap_en     = is_long;
                r_d.f_ebit = !cmd_in;
                r_d.f_crc  = r_q.word[CW_CRC_BIT] && (r_q.rcrc != crc_val);
                r_d.f_idx  = !is_long && (r_q.resp_idx != r_q.word[IDX_W-1:0]);
                r_d.done   = 1'b1;
                r_d.state  = ST_NCC;
                r_d.cnt    = CNT_W'(NCC_CLKS - 1);
            end
            ST_NCC: begin
                if (r_q.cnt == '0) r_d.state = ST_IDLE;
                else               r_d.cnt   = r_q.cnt - CNT_W'(1);
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign seq_state   = r_q.state;
    assign cmd_pending = r_q.go;
    assign cmd_done    = r_q.done;
    assign resp_index  = r_q.resp_idx;
    assign err_timeout = r_q.f_to;
    assign err_crc     = r_q.f_crc;
    assign err_start   = r_q.f_sbit;
    assign err_end     = r_q.f_ebit;
    assign err_index   = r_q.f_idx;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done); // R11

    AST_GO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_IDLE && cmd_pending) |=> !cmd_pending); // R2

    AST_UPD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_IDLE && cmd_pending && r_q.word[CW_UPD_BIT])
        |=> (cmd_done && seq_state == ST_IDLE && !cmd_oe)); // R5

    AST_TIMEOUT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> cmd_done); // R7

    AST_INIT_TO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_INIT && r_q.cnt == '0) |=> seq_state == ST_TX_START); // R4

    AST_NO_IRQ_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_state != ST_RX_IRQ); // R6

    AST_NCC_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && cmd_oe == 1'b0 && seq_state != ST_IDLE) |-> seq_state == ST_NCC); // R12

endmodule

// File: tb/sdc_cmd_seq_test.sv
module sdc_cmd_seq_test;
    localparam int INIT_N = 80;
    localparam int TURN_N = 2;
    localparam int NCC_N  = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_wr = 1'b0;
    logic [31:0]  cmd_word = '0;
    logic [31:0]  cmd_arg = '0;
    logic [7:0]   resp_timeout = 8'd20;
    logic         cmd_in = 1'b1;
    logic         cmd_out, cmd_oe, cmd_pending, cmd_done;
    logic [3:0]   seq_state;
    logic [5:0]   resp_index;
    logic [127:0] resp_data;
    logic         err_timeout, err_crc, err_start, err_end, err_index;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    sdc_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .cmd_arg(cmd_arg), .resp_timeout(resp_timeout), .cmd_in(cmd_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .seq_state(seq_state),
        .cmd_pending(cmd_pending), .cmd_done(cmd_done), .resp_index(resp_index),
        .resp_data(resp_data), .err_timeout(err_timeout), .err_crc(err_crc),
        .err_start(err_start), .err_end(err_end), .err_index(err_index)
    );

    // line monitor
    logic [199:0] cap = '0;
    int           oe_total = 0;
    int           done_total = 0;
    logic         oe_prev = 1'b0;
    logic [3:0]   first_state = '0;

    always @(negedge clk) begin
        if (cmd_oe) begin
            cap      <= {cap[198:0], cmd_out};
            oe_total <= oe_total + 1;
        end
        if (cmd_oe && !oe_prev) first_state <= seq_state;
        if (cmd_done) done_total <= done_total + 1;
        oe_prev <= cmd_oe;
    end

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] crc_of(input logic [135:0] v, input int n);
        logic [6:0] c = '0;
        for (int i = n - 1; i >= 0; i--) begin
            logic fb;
            fb = v[i] ^ c[6];
            c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

    function automatic logic [47:0] mk_short(input logic [5:0] idx, input logic [31:0] pay,
                                             input logic dirb, input logic endb, input logic badc);
        logic [39:0] h;
        logic [6:0]  c;
        h = {1'b0, dirb, idx, pay};
        c = crc_of({96'b0, h}, 40) ^ {6'b0, badc};
        return {h, c, endb};
    endfunction

    task automatic issue(input logic [31:0] w, input logic [31:0] a);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_word = w; cmd_arg = a;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic send_resp(input logic [135:0] bits, input int len, input int gap);
        int g = 0;
        while (!cmd_oe && g < 2000) begin @(negedge clk); g++; end
        while (cmd_oe && g < 4000) begin @(negedge clk); g++; end
        repeat (gap) @(negedge clk);
        for (int i = len - 1; i >= 0; i--) begin
            cmd_in = bits[i];
            @(negedge clk);
        end
        cmd_in = 1'b1;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (!(seq_state == 4'd0 && !cmd_pending) && g < 5000) begin @(negedge clk); g++; end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(seq_state == 0 && !cmd_oe && !cmd_done && !cmd_pending, "R1 idle outputs",
            {seq_state, cmd_oe, cmd_done, cmd_pending}, '0);
        chk({err_timeout, err_crc, err_start, err_end, err_index} == 0, "R1 flags",
            {err_timeout, err_crc, err_start, err_end, err_index}, '0);
    endtask

    task automatic t_plain();
        int o0 = oe_total, d0 = done_total, n = 0;
        logic [39:0] h;
        logic [47:0] fr;
        h  = {2'b01, 6'd17, 32'hA5A5_0F0F};
        fr = {h, crc_of({96'b0, h}, 40), 1'b1};
        issue(32'h8000_0011, 32'hA5A5_0F0F);
        chk(cmd_pending == 1'b1, "R2 pending after write", cmd_pending, 1);
        @(negedge clk);
        chk(cmd_pending == 1'b0, "R2 start self-clears", cmd_pending, 0);
        while (!cmd_done && n < 500) begin @(negedge clk); n++; end
        chk(seq_state == 4'd14, "R12 wait state at done", seq_state, 14);
        n = 0;
        while (seq_state != 0 && n < 100) begin @(negedge clk); n++; end
        chk(n == NCC_N, "R12 wait length", n, NCC_N);
        repeat (2) @(negedge clk);
        chk(oe_total - o0 == 48, "R3 driven bit count", oe_total - o0, 48);
        chk(cap[47:0] == fr, "R3 frame content", cap[47:0], fr);
        chk(first_state == 4'd2, "R6 first driving state", first_state, 2);
        chk(done_total - d0 == 1, "R11 one done", done_total - d0, 1);
    endtask

    task automatic t_init();
        int o0 = oe_total;
        logic [39:0] h;
        logic [47:0] fr;
        h  = {2'b01, 6'd0, 32'h0};
        fr = {h, crc_of({96'b0, h}, 40), 1'b1};
        issue(32'h8000_8000, 32'h0);
        wait_idle();
        chk(oe_total - o0 == INIT_N + 48, "R4 init+frame count", oe_total - o0, INIT_N + 48);
        chk(cap[127:48] == {80{1'b1}}, "R4 init ones", cap[127:48], {80{1'b1}});
        chk(cap[47:0] == fr, "R4 frame after init", cap[47:0], fr);
        chk(first_state == 4'd1, "R6 init state code", first_state, 1);
    endtask

    task automatic t_update();
        int o0 = oe_total, d0 = done_total;
        issue(32'h8020_0040, 32'h1234_5678);
        @(negedge clk);
        chk(cmd_done == 1'b1, "R5 done next clock", cmd_done, 1);
        wait_idle();
        chk(oe_total == o0, "R5 line untouched", oe_total - o0, 0);
        chk(done_total - d0 == 1, "R5 one done", done_total - d0, 1);
        chk({err_timeout, err_crc, err_start, err_end, err_index} == 0, "R5 no flags",
            {err_timeout, err_crc, err_start, err_end, err_index}, 0);
    endtask

    task automatic t_short_ok();
        logic [47:0] r;
        resp_timeout = 8'd5;
        r = mk_short(6'd9, 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b0);
        issue(32'h8000_0149, 32'h0000_0042);
        send_resp({88'b0, r}, 48, TURN_N + 5 - 1);
        wait_idle();
        chk(!err_timeout, "R7 start in last window clock", err_timeout, 0);
        chk(resp_index == 6'd9, "R8 index stored", resp_index, 9);
        chk(resp_data == {96'b0, 32'hDEAD_BEEF}, "R8 short payload", resp_data, {96'b0, 32'hDEAD_BEEF});
        chk({err_crc, err_start, err_end, err_index} == 0, "R10 clean short",
            {err_crc, err_start, err_end, err_index}, 0);
    endtask

    task automatic t_timeout(input logic [7:0] to, input int exp_n);
        int n = 0, g = 0, d0 = done_total;
        resp_timeout = to;
        issue(32'h8000_0045, 32'h0);
        while (!cmd_oe && g < 2000) begin @(negedge clk); g++; end
        while (cmd_oe && g < 4000) begin @(negedge clk); g++; end
        while (!cmd_done && n < 1000) begin @(negedge clk); n++; end
        chk(n == exp_n, "R7 timeout latency", n, exp_n);
        chk(err_timeout == 1'b1, "R7 timeout flag", err_timeout, 1);
        wait_idle();
        chk(done_total - d0 == 1 && err_timeout, "R11 flag holds, one done", done_total - d0, 1);
    endtask

    task automatic t_long();
        logic [119:0] p;
        logic [6:0]   c;
        logic [135:0] fr;
        p  = {30'h1ABC_DEF0, 30'h0123_4567, 30'h2BAD_CAFE, 30'h0F0F_5A5A};
        c  = crc_of({16'b0, p}, 120);
        fr = {2'b00, 6'h3F, p, c, 1'b1};
        resp_timeout = 8'd20;
        issue(32'h8000_01C2, 32'h0);
        send_resp(fr, 136, 3);
        wait_idle();
        chk(resp_data == {p, c, 1'b1}, "R9 long capture", resp_data, {p, c, 1'b1});
        chk(!err_crc && !err_index && !err_end && !err_start, "R9 long crc over payload",
            {err_crc, err_index, err_end, err_start}, 0);
        chk(resp_index == 6'h3F, "R9 long index field", resp_index, 6'h3F);
    endtask

    task automatic t_errors();
        logic [47:0] r;
        resp_timeout = 8'd20;
        r = mk_short(6'd5, 32'h0000_1111, 1'b0, 1'b1, 1'b1);
        issue(32'h8000_0145, 32'h0);
        send_resp({88'b0, r}, 48, 3);
        wait_idle();
        chk(err_crc == 1'b1, "R10 crc error flagged", err_crc, 1);
        issue(32'h8000_0045, 32'h0);
        send_resp({88'b0, r}, 48, 3);
        wait_idle();
        chk(err_crc == 1'b0, "R10 crc check disabled", err_crc, 0);
        r = mk_short(6'd6, 32'h0000_2222, 1'b1, 1'b0, 1'b0);
        issue(32'h8000_0145, 32'h0);
        send_resp({88'b0, r}, 48, 3);
        wait_idle();
        chk(err_start == 1'b1, "R10 start error", err_start, 1);
        chk(err_end == 1'b1, "R10 end error", err_end, 1);
        chk(err_index == 1'b1, "R8 index mismatch", err_index, 1);
        chk(err_crc == 1'b0, "R11 stale crc flag cleared", err_crc, 0);
    endtask

    task automatic t_busy_write();
        int o0 = oe_total, d0 = done_total;
        issue(32'h8000_0003, 32'h0);
        repeat (10) @(negedge clk);
        cmd_wr = 1'b1; cmd_word = 32'h8000_0004; cmd_arg = 32'hFFFF_FFFF;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(cmd_pending == 1'b0, "R2 write while busy ignored", cmd_pending, 0);
        wait_idle();
        repeat (10) @(negedge clk);
        chk(oe_total - o0 == 48 && done_total - d0 == 1, "R2 no second command",
            oe_total - o0, 48);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_init();
        t_update();
        t_short_ok();
        t_timeout(8'd5, TURN_N + 5);
        t_timeout(8'd0, TURN_N + 256);
        t_long();
        t_errors();
        t_busy_write();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog act=expired exp=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule